// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one compare channel of a general-purpose timer. The timer core drives it with the running count value, the count direction, a one-cycle update-event pulse and a one-cycle trigger-edge pulse. The channel compares the count with an active compare value and drives two outputs. The first is a registered reference output that is active high. The second is a pin output whose active level is set by a polarity bit.

A small register interface writes the compare value and the channel configuration. The configuration holds a 3-bit output mode, a buffer enable, a fast-trigger enable and the output polarity. When buffering is off, a compare write goes straight into the active (shadow) compare register. When buffering is on, writes land in a buffer register, and the buffer is copied into the shadow register at each update event.

There are eight output modes:
- a frozen mode;
- set on match, clear on match and toggle on match;
- two forced levels;
- two PWM modes that take the count direction into account.

In the PWM modes a trigger edge can also act as a compare match.

Top module: `oc_channel`

## Requirements
- R1: While reset is held and on the cycle after it is released, `oc_ref_o`, `oc_pin_o` and `cmp_rdata_o` are all 0. After reset the configuration is mode 3'b000 (frozen), buffering off, fast trigger off and polarity 0, and both compare registers hold 0.
- R2: In mode 3'b000 (frozen) the reference output keeps its level, whatever the count or the compare value.
- R3: In mode 3'b001 the reference output goes to 1 on the clock edge at which `cnt_i` equals the active compare value. In mode 3'b010 it goes to 0 on that edge. At any other count it keeps its level.
- R4: In mode 3'b011 the reference output inverts on each clock edge at which `cnt_i` equals the active compare value. At any other count it keeps its level.
- R5: Mode 3'b100 drives the reference output to 0 and mode 3'b101 drives it to 1, independent of the count.
- R6: Mode 3'b110 (PWM A) works as follows.
  - Counting up (`cnt_down_i`=0): the reference output is 1 while count < compare and 0 otherwise.
  - Counting down (`cnt_down_i`=1): it is 0 while count > compare and 1 otherwise.
- R7: Mode 3'b111 (PWM B) gives the complement of the PWM A level in both count directions.
- R8: In the PWM modes the reference output takes the comparison level on entry from any non-PWM mode, and after that only when the comparison level changes. A level change takes precedence over a trigger edge in the same cycle.
- R9: With buffering off, a compare write reaches the active compare register on the write edge, so comparisons use the new value from the following edge on.
- R10: Buffered compare writes work as follows.
  - With buffering on, a compare write changes only the buffer, and `cmp_rdata_o` returns the buffer contents.
  - An update-event pulse copies the buffer into the active compare register.
  - If a write and an update fall on the same edge, the active register takes the buffer value from before that write.
- R11: Fast trigger behaves as follows.
  - When fast trigger is on in a PWM mode, a trigger-edge pulse (with no level change in that cycle) drives the reference output, on that edge, to the level the mode gives at count equal to compare. That level is 0 for PWM A counting up, 1 for PWM A counting down, and the inverse of these for PWM B.
  - The reference output then holds that level until the comparison level changes.
  - With fast trigger off, or in a non-PWM mode, trigger pulses have no effect.
- R12: `oc_pin_o` equals `oc_ref_o` XOR the polarity bit, and both outputs update on the same edge.
- R13: A configuration write on one edge takes effect for the compare evaluated at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Counter value from the timer core |
| cnt_down_i | input | 1 | 1 while the counter counts down |
| upd_evt_i | input | 1 | Update-event pulse |
| trig_edge_i | input | 1 | Trigger-edge pulse |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Output mode to write |
| cfg_buf_en_i | input | 1 | Compare buffering enable to write |
| cfg_fast_en_i | input | 1 | Fast trigger enable to write |
| cfg_pol_i | input | 1 | Pin polarity to write (1 = inverted) |
| cmp_rdata_o | output | CNT_W | Compare readback (buffer register) |
| oc_ref_o | output | 1 | Active-high reference output |
| oc_pin_o | output | 1 | Polarity-adjusted pin output |

## Verification
Each mode is driven with count sweeps that cross the compare value in both directions. These sweeps show whether the strict and inclusive comparison boundaries sit at the right place, and whether a match acts on the right edge. Compare writes are made both with and without buffering, and around update pulses, so that the bench can tell an immediate load from a deferred one, including the case where a write and an update fall on the same edge. Trigger pulses are sent with fast trigger on and off, in PWM and non-PWM modes. Mode entries from forced levels tell the entry rule apart from the change-only rule. Polarity is flipped within these runs so that the pin path is checked against the reference output.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OC_FROZEN    = 3'b000,
    OC_SET_MATCH = 3'b001,
    OC_CLR_MATCH = 3'b010,
    OC_TOGGLE    = 3'b011,
    OC_FORCE_LO  = 3'b100,
    OC_FORCE_HI  = 3'b101,
    OC_PWM_A     = 3'b110,
    OC_PWM_B     = 3'b111
  } oc_mode_e;

  typedef struct packed {
    oc_mode_e mode;
    logic     buf_en;
    logic     fast_en;
    logic     pol;
  } oc_cfg_t;

  localparam oc_cfg_t OC_CFG_RST = '{mode: OC_FROZEN, buf_en: 1'b0, fast_en: 1'b0, pol: 1'b0};

endpackage

// File: rtl/oc_cfg_reg.sv
module oc_cfg_reg
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] mode_in,
  input  logic       buf_en_in,
  input  logic       fast_en_in,
  input  logic       pol_in,
  output oc_cfg_t    cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= OC_CFG_RST;
    end else if (we) begin
      cfg_q.mode    <= oc_mode_e'(mode_in);
      cfg_q.buf_en  <= buf_en_in;
      cfg_q.fast_en <= fast_en_in;
      cfg_q.pol     <= pol_in;
    end
  end

endmodule

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buf_en,
  input  logic         upd_evt,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q
);

  // The buffer register is always written; it is also the readback source.
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else if (we) begin
      buf_q <= wdata;
    end
  end

  // The shadow register loads at once when unbuffered, or from the buffer on an update.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (!buf_en && we) begin
      act_q <= wdata;
    end else if (buf_en && upd_evt) begin
      act_q <= buf_q;
    end
  end

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         cnt_down,
  input  logic         trig,
  input  logic [W-1:0] cmp,
  input  oc_mode_e     mode,
  input  logic         fast_en,
  output logic         ref_d,
  output logic         ref_q
);

  logic match, below, above, lvl_a, lvl, fast_lvl, is_pwm;
  logic lvl_q, was_pwm_q;

  always_comb begin
    match    = (cnt == cmp);
    below    = (cnt < cmp);
    above    = (cnt > cmp);
    lvl_a    = cnt_down ? !above : below;
    is_pwm   = (mode == OC_PWM_A) || (mode == OC_PWM_B);
    lvl      = (mode == OC_PWM_B) ? !lvl_a : lvl_a;
    fast_lvl = (mode == OC_PWM_B) ? !cnt_down : cnt_down;
    unique case (mode)
      OC_FROZEN:    ref_d = ref_q;
      OC_SET_MATCH: ref_d = match ? 1'b1 : ref_q;
      OC_CLR_MATCH: ref_d = match ? 1'b0 : ref_q;
      OC_TOGGLE:    ref_d = match ? !ref_q : ref_q;
      OC_FORCE_LO:  ref_d = 1'b0;
      OC_FORCE_HI:  ref_d = 1'b1;
      default: begin
        if (!was_pwm_q || (lvl != lvl_q)) ref_d = lvl;
        else if (fast_en && trig)         ref_d = fast_lvl;
        else                              ref_d = ref_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= 1'b0;
      lvl_q     <= 1'b0;
      was_pwm_q <= 1'b0;
    end else begin
      ref_q     <= ref_d;
      lvl_q     <= lvl;
      was_pwm_q <= is_pwm;
    end
  end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_evt_i,
  input  logic             trig_edge_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_buf_en_i,
  input  logic             cfg_fast_en_i,
  input  logic             cfg_pol_i,
  output logic [CNT_W-1:0] cmp_rdata_o,
  output logic             oc_ref_o,
  output logic             oc_pin_o
);

  oc_cfg_t          cfg_q;
  logic [CNT_W-1:0] cmp_buf;
  logic [CNT_W-1:0] cmp_act;
  logic             ref_d;
  logic             pin_q;

  oc_cfg_reg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we_i),
    .mode_in    (cfg_mode_i),
    .buf_en_in  (cfg_buf_en_i),
    .fast_en_in (cfg_fast_en_i),
    .pol_in     (cfg_pol_i),
    .cfg_q      (cfg_q)
  );

  oc_cmp_store #(.W(CNT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .buf_en  (cfg_q.buf_en),
    .upd_evt (upd_evt_i),
    .we      (cmp_we_i),
    .wdata   (cmp_wdata_i),
    .buf_q   (cmp_buf),
    .act_q   (cmp_act)
  );

  oc_ref_gen #(.W(CNT_W)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_i),
    .cnt_down (cnt_down_i),
    .trig     (trig_edge_i),
    .cmp      (cmp_act),
    .mode     (cfg_q.mode),
    .fast_en  (cfg_q.fast_en),
    .ref_d    (ref_d),
    .ref_q    (oc_ref_o)
  );

  // The pin is registered on the same edge as the reference output.
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= ref_d ^ cfg_q.pol;
  end

  assign oc_pin_o    = pin_q;
  assign cmp_rdata_o = cmp_buf;

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_i,
  input logic             upd_evt_i,
  input logic             ref_o,
  input logic             pin_o,
  input oc_cfg_t          cfg,
  input logic [CNT_W-1:0] cmp_act
);

  a_r12_pin_polarity: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pin_o == (ref_o ^ $past(cfg.pol))));

  a_r2_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == OC_FROZEN) |=> $stable(ref_o));

  a_r5_force_low: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == OC_FORCE_LO) |=> !ref_o);

  a_r5_force_high: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == OC_FORCE_HI) |=> ref_o);

  a_r3_set_on_match: assert property (@(posedge clk) disable iff (rst)
    ((cfg.mode == OC_SET_MATCH) && (cnt_i == cmp_act)) |=> ref_o);

  a_r10_shadow_waits: assert property (@(posedge clk) disable iff (rst)
    (cfg.buf_en && !upd_evt_i) |=> $stable(cmp_act));

endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_i     (cnt_i),
  .upd_evt_i (upd_evt_i),
  .ref_o     (oc_ref_o),
  .pin_o     (oc_pin_o),
  .cfg       (cfg_q),
  .cmp_act   (cmp_act)
);

// File: tb/tb_oc_channel.sv
module tb_oc_channel;

  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt_i = '0;
  logic          cnt_down_i = 1'b0, upd_evt_i = 1'b0, trig_edge_i = 1'b0;
  logic          cmp_we_i = 1'b0;
  logic [CW-1:0] cmp_wdata_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_mode_i = '0;
  logic          cfg_buf_en_i = 1'b0, cfg_fast_en_i = 1'b0, cfg_pol_i = 1'b0;
  logic [CW-1:0] cmp_rdata_o;
  logic          oc_ref_o, oc_pin_o;

  always #(CLK_P/2) clk = ~clk;

  oc_channel #(.CNT_W(CW)) dut (.*);

  typedef struct {
    logic          r;
    logic          p;
    logic [CW-1:0] rd;
    string         tag;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0, fails = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // pending register writes, applied by the next tick
  bit            p_cmp_we = 0, p_cfg_we = 0;
  logic [CW-1:0] p_cmp_wd = '0;
  int            p_mode = 0;
  bit            p_buf = 0, p_fast = 0, p_pol = 0;

  // behavioural model state
  int            m_mode = 0;
  bit            m_buf = 0, m_fast = 0, m_pol = 0;
  logic [CW-1:0] m_bufv = '0, m_act = '0;
  bit            m_ref = 0, m_lvl = 0, m_inpwm = 0;

  task automatic set_cmp(input int v);
    p_cmp_we = 1; p_cmp_wd = CW'(v);
  endtask

  task automatic set_cfg(input int mode, input bit bf, input bit fs, input bit pl);
    p_cfg_we = 1; p_mode = mode; p_buf = bf; p_fast = fs; p_pol = pl;
  endtask

  task automatic tick(input int c, input bit dn, input bit up, input bit tg);
    bit   hit, hi_lvl, nr, pwm;
    exp_t e;
    @(negedge clk);
    cnt_i = CW'(c); cnt_down_i = dn; upd_evt_i = up; trig_edge_i = tg;
    cmp_we_i = p_cmp_we; cmp_wdata_i = p_cmp_wd;
    cfg_we_i = p_cfg_we; cfg_mode_i = 3'(p_mode);
    cfg_buf_en_i = p_buf; cfg_fast_en_i = p_fast; cfg_pol_i = p_pol;
    hit = (CW'(c) == m_act);
    // PWM A level: up -> high below compare; down -> low above compare
    if (dn) hi_lvl = !(CW'(c) > m_act);
    else    hi_lvl = (CW'(c) < m_act);
    if (m_mode == 7) hi_lvl = !hi_lvl;
    pwm = (m_mode >= 6);
    case (m_mode)
      1: nr = hit ? 1'b1 : m_ref;
      2: nr = hit ? 1'b0 : m_ref;
      3: nr = hit ? !m_ref : m_ref;
      4: nr = 1'b0;
      5: nr = 1'b1;
      6, 7: begin
        if (!m_inpwm || hi_lvl != m_lvl) nr = hi_lvl;
        else if (m_fast && tg)           nr = (m_mode == 6) ? dn : !dn;
        else                             nr = m_ref;
      end
      default: nr = m_ref;
    endcase
    e.p = nr ^ m_pol;
    if (p_cmp_we && !m_buf) m_act = p_cmp_wd;
    else if (m_buf && up)   m_act = m_bufv;
    if (p_cmp_we) m_bufv = p_cmp_wd;
    if (p_cfg_we) begin
      m_mode = p_mode; m_buf = p_buf; m_fast = p_fast; m_pol = p_pol;
    end
    m_ref = nr; m_lvl = hi_lvl; m_inpwm = pwm;
    e.r = nr; e.rd = m_bufv; e.tag = cur_tag;
    sb.push_back(e);
    p_cmp_we = 0; p_cfg_we = 0;
  endtask

  task automatic sweep(input int from, input int to, input bit dn);
    if (from <= to) for (int i = from; i <= to; i++) tick(i, dn, 0, 0);
    else            for (int i = from; i >= to; i--) tick(i, dn, 0, 0);
  endtask

  // monitor: pops the expected item for each edge and compares
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (oc_ref_o !== e.r || oc_pin_o !== e.p || cmp_rdata_o !== e.rd) begin
        fails++;
        $display("FAIL %s: ref/pin/rd actual %b/%b/%0d expected %b/%b/%0d",
                 e.tag, oc_ref_o, oc_pin_o, cmp_rdata_o, e.r, e.p, e.rd);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R1: reset state
    checks++;
    if (oc_ref_o !== 1'b0 || oc_pin_o !== 1'b0 || cmp_rdata_o !== '0) begin
      fails++;
      $display("FAIL R1: ref/pin/rd actual %b/%b/%0d expected 0/0/0", oc_ref_o, oc_pin_o, cmp_rdata_o);
    end
    tick(0, 0, 0, 0);

    // R9: unbuffered write, R2: frozen holds low
    cur_tag = "R9"; set_cmp(5); tick(0, 0, 0, 0);
    cur_tag = "R2"; sweep(0, 10, 0);

    // R3: set and clear on match, with trigger ignored (R11)
    cur_tag = "R3"; set_cfg(1, 0, 1, 0); tick(0, 0, 0, 0);
    sweep(0, 8, 0);
    set_cfg(2, 0, 0, 0); tick(0, 0, 0, 0);
    sweep(2, 7, 0);
    cur_tag = "R11"; tick(3, 0, 0, 1);

    // R4: toggle, with inverted pin (R12)
    cur_tag = "R4"; set_cfg(3, 0, 0, 1); tick(0, 0, 0, 0);
    sweep(0, 12, 0); sweep(12, 0, 1);

    // R5: forced levels; R2: frozen holds a high level
    cur_tag = "R5"; set_cfg(5, 0, 0, 0); sweep(0, 3, 0);
    set_cfg(4, 0, 0, 1); sweep(4, 6, 0);
    set_cfg(5, 0, 0, 0); tick(7, 0, 0, 0);
    cur_tag = "R2"; set_cfg(0, 0, 0, 0); sweep(0, 9, 0);

    // R8: entry into PWM from forced high with count above compare
    cur_tag = "R8"; set_cfg(5, 0, 0, 0); tick(9, 0, 0, 0);
    set_cfg(6, 0, 0, 0); tick(9, 0, 0, 0); tick(9, 0, 0, 0);

    // R6: PWM A both directions
    cur_tag = "R6"; sweep(0, 9, 0); sweep(9, 0, 1);

    // R7: PWM B both directions, inverted pin (R12)
    cur_tag = "R7"; set_cfg(7, 0, 0, 1); tick(0, 0, 0, 0);
    sweep(0, 9, 0); sweep(9, 0, 1);

    // R11: fast trigger in PWM A and B
    cur_tag = "R11"; set_cfg(6, 0, 1, 0); tick(0, 0, 0, 0);
    tick(1, 0, 0, 0); tick(2, 0, 0, 1); tick(3, 0, 0, 0); sweep(4, 8, 0);
    sweep(8, 7, 1); tick(6, 1, 0, 0); tick(6, 1, 0, 1); sweep(6, 3, 1);
    set_cfg(7, 0, 1, 0); tick(0, 0, 0, 0);
    tick(1, 0, 0, 0); tick(2, 0, 0, 1); sweep(3, 8, 0);
    set_cfg(6, 0, 0, 0); tick(1, 0, 0, 0); tick(2, 0, 0, 0); tick(3, 0, 0, 1);
    cur_tag = "R8"; tick(4, 0, 0, 1); tick(5, 0, 0, 1);

    // R10: buffered compare value
    cur_tag = "R10"; set_cfg(1, 1, 0, 0); tick(0, 0, 0, 0);
    set_cmp(9); tick(0, 0, 0, 0);
    set_cfg(2, 1, 0, 0); sweep(1, 6, 0);
    sweep(7, 10, 0);
    tick(0, 0, 1, 0);
    set_cfg(1, 1, 0, 0); tick(0, 0, 0, 0);
    sweep(1, 10, 0);
    set_cmp(3); tick(0, 0, 1, 0);
    set_cfg(3, 1, 0, 0); tick(0, 0, 0, 0);
    sweep(1, 10, 0);
    tick(0, 0, 1, 0); sweep(1, 4, 0);

    // R13: config change applies from the next compare
    cur_tag = "R13"; set_cfg(5, 0, 0, 0); tick(1, 0, 0, 0); tick(1, 0, 0, 0);
    set_cfg(4, 0, 0, 1); tick(1, 0, 0, 0); tick(1, 0, 0, 0);
    set_cfg(0, 0, 0, 0); tick(1, 0, 0, 0); tick(2, 0, 0, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule